// File: doc/BRIEF.md
# Pipelined Signed Multiply-Adder

This block takes four signed 16-bit operands every clock cycle, multiplies them in two pairs and returns either the sum or the difference of the two products. A single select input, sampled together with the operands, picks which. The result comes out of a 33-bit signed register exactly three clock edges after the operands were presented, and a new set of operands can be accepted on every edge.

The datapath has three register stages: one that captures the operands and the select, one that holds the two products and the delayed select, and one that holds the result. The combining logic has two levels. The first level either passes the second product through or negates it, as the select asks. The second level always adds that term to the first product. A clock enable stalls every stage at once. An asynchronous clear forces every stage to zero at any time, without waiting for a clock edge.

Top module: `madd_pipe`

## Requirements
- R1: The two products are formed from fixed pairs: `x0` times `y0` and `x1` times `y1`. All four operands are two's complement values.
- R2: When `sub` is 0, the result is `x0*y0 + x1*y1`. When `sub` is 1, the result is `x0*y0 - x1*y1`.
- R3: While `ce` is high, the result for the operands sampled at rising edge N appears on `res` just after rising edge N+2. This is a latency of three register stages, with a new result on every edge.
- R4: `sub` travels down the pipeline with its own operands. If `sub` changes on every cycle, each result still uses the select that was sampled together with its operands.
- R5: While `ce` is low, no stage changes and `res` holds its value. When `ce` returns high, the pipeline continues from where it stopped, and no operand set is lost or repeated.
- R6: While `aclr` is high, all three stages are zero and `res` reads 0, even between clock edges. After `aclr` is released, `res` stays 0 for the first three rising edges. It is 0 until operands sampled after the release have passed through all three stages.
- R7: `res` is 33 bits wide, two's complement. It holds the exact result for every operand combination, with no overflow. The extreme cases are all four operands at -32768 (sum +2^31, difference 0) and mixed extremes such as `x0=y0=-32768`, `x1=32767`, `y1=-32768`, `sub=1` (result 2^31-32768).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| aclr | input | 1 | Asynchronous clear, active high; forces all stages to zero |
| ce | input | 1 | Clock enable; when low, every stage holds its value |
| sub | input | 1 | Combine select: 0 adds the second product, 1 subtracts it |
| x0 | input | 16 | First operand of the first product, signed |
| y0 | input | 16 | Second operand of the first product, signed |
| x1 | input | 16 | First operand of the second product, signed |
| y1 | input | 16 | Second operand of the second product, signed |
| res | output | 33 | Registered signed result |

## Verification
Each result is due just after the third enabled rising edge that follows the moment its operands and select were driven. Rising edges with `ce` low do not count toward those three edges. The bench drives operands on falling edges and keeps its own three-entry queue of expected values, computed arithmetically. The queue advances only on edges where the bench held `ce` high, and each falling edge compares `res` with the oldest entry in the queue. A clear empties the queue to zeros, so the zero results expected after a clear come from the same comparison. Both of these timing rules are also checked by a property that looks three enabled edges back.

// File: rtl/madd_pkg.sv
package madd_pkg;

    // Selects how the first combining level treats the second product
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } comb_op_e;

endpackage

// File: rtl/madd_operand_stage.sv
module madd_operand_stage
    import madd_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_OPS = 4
) (
    input  logic                     clk,
    input  logic                     aclr,
    input  logic                     ce,
    input  comb_op_e                 op_i,
    input  logic signed [DATA_W-1:0] opnd_i [NUM_OPS],
    output comb_op_e                 op_q,
    output logic signed [DATA_W-1:0] opnd_q [NUM_OPS]
);

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            op_q <= OP_ADD;
            for (int i = 0; i < NUM_OPS; i++) opnd_q[i] <= '0;
        end else if (ce) begin
            op_q <= op_i;
            for (int i = 0; i < NUM_OPS; i++) opnd_q[i] <= opnd_i[i];
        end
    end

endmodule

// File: rtl/madd_product_stage.sv
module madd_product_stage
    import madd_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_PROD = 2,
    localparam int NUM_OPS = 2 * NUM_PROD,
    localparam int PROD_W  = 2 * DATA_W
) (
    input  logic                     clk,
    input  logic                     aclr,
    input  logic                     ce,
    input  comb_op_e                 op_i,
    input  logic signed [DATA_W-1:0] opnd_i [NUM_OPS],
    output comb_op_e                 op_q,
    output logic signed [PROD_W-1:0] prod_q [NUM_PROD]
);

    logic signed [PROD_W-1:0] prod_c [NUM_PROD];

    // One multiplier per operand pair
    for (genvar g = 0; g < NUM_PROD; g++) begin : g_mul
        assign prod_c[g] = PROD_W'(opnd_i[2*g]) * PROD_W'(opnd_i[2*g+1]);
    end

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            op_q <= OP_ADD;
            for (int i = 0; i < NUM_PROD; i++) prod_q[i] <= '0;
        end else if (ce) begin
            op_q <= op_i;
            for (int i = 0; i < NUM_PROD; i++) prod_q[i] <= prod_c[i];
        end
    end

endmodule

// File: rtl/madd_combine_stage.sv
module madd_combine_stage
    import madd_pkg::*;
#(
    parameter int PROD_W = 32,
    localparam int RES_W = PROD_W + 1
) (
    input  logic                     clk,
    input  logic                     aclr,
    input  logic                     ce,
    input  comb_op_e                 op_i,
    input  logic signed [PROD_W-1:0] prod_a_i,
    input  logic signed [PROD_W-1:0] prod_b_i,
    output logic signed [RES_W-1:0]  res_q
);

    logic signed [RES_W-1:0] ext_a;
    logic signed [RES_W-1:0] ext_b;
    logic signed [RES_W-1:0] term_b;
    logic signed [RES_W-1:0] sum_c;

    assign ext_a = RES_W'(prod_a_i);
    assign ext_b = RES_W'(prod_b_i);

    // First level: pass or negate the second product
    always_comb begin
        unique case (op_i)
            OP_ADD:  term_b = ext_b;
            OP_SUB:  term_b = -ext_b;
            default: term_b = ext_b;
        endcase
    end

    // Second level: always an addition
    assign sum_c = ext_a + term_b;

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr)    res_q <= '0;
        else if (ce) res_q <= sum_c;
    end

endmodule

// File: rtl/madd_pipe.sv
module madd_pipe
    import madd_pkg::*;
#(
    parameter int DATA_W   = 16,
    localparam int NUM_PROD = 2,
    localparam int NUM_OPS  = 2 * NUM_PROD,
    localparam int PROD_W   = 2 * DATA_W,
    localparam int RES_W    = PROD_W + 1
) (
    input  logic                     clk,
    input  logic                     aclr,
    input  logic                     ce,
    input  logic                     sub,
    input  logic signed [DATA_W-1:0] x0,
    input  logic signed [DATA_W-1:0] y0,
    input  logic signed [DATA_W-1:0] x1,
    input  logic signed [DATA_W-1:0] y1,
    output logic signed [RES_W-1:0]  res
);

    logic signed [DATA_W-1:0] opnd_in [NUM_OPS];
    logic signed [DATA_W-1:0] opnd_r  [NUM_OPS];
    logic signed [PROD_W-1:0] prod_r  [NUM_PROD];
    comb_op_e                 op_in;
    comb_op_e                 op_s1;
    comb_op_e                 op_s2;

    assign opnd_in[0] = x0;
    assign opnd_in[1] = y0;
    assign opnd_in[2] = x1;
    assign opnd_in[3] = y1;
    assign op_in      = sub ? OP_SUB : OP_ADD;

    madd_operand_stage #(.DATA_W(DATA_W), .NUM_OPS(NUM_OPS)) u_opnd (
        .clk    (clk),
        .aclr   (aclr),
        .ce     (ce),
        .op_i   (op_in),
        .opnd_i (opnd_in),
        .op_q   (op_s1),
        .opnd_q (opnd_r)
    );

    madd_product_stage #(.DATA_W(DATA_W), .NUM_PROD(NUM_PROD)) u_prod (
        .clk    (clk),
        .aclr   (aclr),
        .ce     (ce),
        .op_i   (op_s1),
        .opnd_i (opnd_r),
        .op_q   (op_s2),
        .prod_q (prod_r)
    );

    madd_combine_stage #(.PROD_W(PROD_W)) u_comb (
        .clk      (clk),
        .aclr     (aclr),
        .ce       (ce),
        .op_i     (op_s2),
        .prod_a_i (prod_r[0]),
        .prod_b_i (prod_r[1]),
        .res_q    (res)
    );

endmodule

// File: rtl/madd_pipe_chk.sv
module madd_pipe_chk #(
    parameter int DATA_W = 16,
    parameter int RES_W  = 33
) (
    input logic                     clk,
    input logic                     aclr,
    input logic                     ce,
    input logic                     sub,
    input logic signed [DATA_W-1:0] x0,
    input logic signed [DATA_W-1:0] y0,
    input logic signed [DATA_W-1:0] x1,
    input logic signed [DATA_W-1:0] y1,
    input logic signed [RES_W-1:0]  res
);

    logic signed [RES_W-1:0] exp_now;
    logic [1:0]              seen;

    always_comb begin
        if (sub) exp_now = RES_W'(x0) * RES_W'(y0) - RES_W'(x1) * RES_W'(y1);
        else     exp_now = RES_W'(x0) * RES_W'(y0) + RES_W'(x1) * RES_W'(y1);
    end

    // Edges since the clear was released, saturating at three
    always_ff @(posedge clk or posedge aclr) begin
        if (aclr)              seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    // R3, R4, R1, R2: three enabled edges give the matching result
    a_r3_latency: assert property (@(posedge clk) disable iff (aclr)
        (seen == 2'd3 && $past(ce) && $past(ce, 2) && $past(ce, 3))
            |-> res == $past(exp_now, 3));

    a_r5_hold: assert property (@(posedge clk) disable iff (aclr)
        !ce |=> $stable(res));

    a_r6_clear_zero: assert property (@(posedge clk)
        aclr |-> res == '0);

    a_r6_release_zero: assert property (@(posedge clk) disable iff (aclr)
        seen <= 2'd2 |-> res == '0);

endmodule

bind madd_pipe madd_pipe_chk #(.DATA_W(DATA_W), .RES_W(RES_W)) u_chk (
    .clk  (clk),
    .aclr (aclr),
    .ce   (ce),
    .sub  (sub),
    .x0   (x0),
    .y0   (y0),
    .x1   (x1),
    .y1   (y1),
    .res  (res)
);

// File: tb/madd_pipe_test.sv
`timescale 1ns/1ps
module madd_pipe_test;

    logic               clk = 1'b0;
    logic               aclr;
    logic               ce;
    logic               sub;
    logic signed [15:0] x0, y0, x1, y1;
    logic signed [32:0] res;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Expected-value queue: q2 is the value due on res now
    logic signed [32:0] q0, q1, q2;

    always #10 clk = ~clk;

    madd_pipe uut (
        .clk(clk), .aclr(aclr), .ce(ce), .sub(sub),
        .x0(x0), .y0(y0), .x1(x1), .y1(y1), .res(res)
    );

    function automatic logic signed [15:0] corner(input int i);
        case (i)
            0:       return 16'sd0;
            1:       return 16'sd1;
            2:       return -16'sd1;
            3:       return 16'sd32767;
            4:       return -16'sd32768;
            5:       return -16'sd32767;
            6:       return 16'sd2;
            default: return -16'sd1234;
        endcase
    endfunction

    function automatic logic signed [32:0] model(input logic signed [15:0] a, b, c, d,
                                                 input logic s);
        longint pa, pb;
        pa = longint'(a) * longint'(b);
        pb = longint'(c) * longint'(d);
        return s ? 33'(pa - pb) : 33'(pa + pb);
    endfunction

    task automatic check(input string tag, input logic signed [32:0] want);
        checks++;
        if (res !== want) begin
            failures++;
            $display("FAIL %s res=%0d expected=%0d", tag, res, want);
        end
    endtask

    // Called at a falling edge: check the due result, drive, pass one rising edge
    task automatic step(input string tag, input logic signed [15:0] a, b, c, d,
                        input logic s, input logic en);
        check(tag, q2);
        x0 = a; y0 = b; x1 = c; y1 = d; sub = s; ce = en;
        @(posedge clk);
        if (en) begin
            q2 = q1; q1 = q0; q0 = model(a, b, c, d, s);
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R3 watchdog expired res=%0d expected=end of run", res);
            finish_run();
        end
    end

    initial begin
        aclr = 1'b1; ce = 1'b0; sub = 1'b0;
        x0 = '0; y0 = '0; x1 = '0; y1 = '0;
        q0 = '0; q1 = '0; q2 = '0;
        @(negedge clk);
        @(negedge clk);
        check("R6 reset state", 33'sd0);
        aclr = 1'b0;

        // R6: zeros for the first three edges after release
        step("R6 release", 16'sd300, 16'sd7, 16'sd5, 16'sd9, 1'b0, 1'b1);
        step("R6 release", 16'sd1, 16'sd1, 16'sd1, 16'sd1, 1'b1, 1'b1);
        step("R6 release", 16'sd0, 16'sd0, 16'sd0, 16'sd0, 1'b0, 1'b1);

        // R3: single impulse surrounded by zeros
        step("R3 impulse", 16'sd123, -16'sd45, 16'sd6, 16'sd7, 1'b1, 1'b1);
        for (int k = 0; k < 4; k++)
            step("R3 impulse", 16'sd0, 16'sd0, 16'sd0, 16'sd0, 1'b0, 1'b1);

        // R1, R2, R4: sweep of corner values, select toggling every cycle
        for (int s0 = 0; s0 < 2; s0++)
            for (int ia = 0; ia < 8; ia++)
                for (int ib = 0; ib < 8; ib++)
                    for (int ic = 0; ic < 8; ic++)
                        for (int id = 0; id < 8; id++)
                            step((s0 == 0) ? "R1 R4 sweep" : "R2 R4 sweep",
                                 corner(ia), corner(ib), corner(ic), corner(id),
                                 logic'((id + s0) % 2), 1'b1);

        // R7: extremes
        step("R7 extreme", -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, 1'b0, 1'b1);
        step("R7 extreme", -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, 1'b1, 1'b1);
        step("R7 extreme", -16'sd32768, -16'sd32768, 16'sd32767, -16'sd32768, 1'b1, 1'b1);
        step("R7 extreme", 16'sd32767, -16'sd32768, -16'sd32768, -16'sd32768, 1'b0, 1'b1);
        step("R7 extreme", 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++)
            step("R7 extreme", 16'sd0, 16'sd0, 16'sd0, 16'sd0, 1'b0, 1'b1);

        // R5: random operands with random stalls
        for (int k = 0; k < 2000; k++)
            step("R5 stall", 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                 logic'($urandom % 2), logic'(($urandom % 4) != 0));
        // R5: long stall, then resume
        for (int k = 0; k < 6; k++)
            step("R5 long stall", 16'($urandom), 16'($urandom), 16'($urandom),
                 16'($urandom), 1'b1, 1'b0);
        for (int k = 0; k < 4; k++)
            step("R5 resume", 16'($urandom), 16'($urandom), 16'($urandom),
                 16'($urandom), 1'b0, 1'b1);

        // R6: clear raised between edges while data is in flight
        #5;
        aclr = 1'b1;
        #1;
        q0 = '0; q1 = '0; q2 = '0;
        check("R6 async clear", 33'sd0);
        @(negedge clk);
        check("R6 clear held", 33'sd0);
        aclr = 1'b0;
        for (int k = 0; k < 3; k++)
            step("R6 after clear", 16'sd1000, -16'sd77, 16'sd4, 16'sd4, logic'(k % 2), 1'b1);
        for (int k = 0; k < 4; k++)
            step("R3 flush", 16'sd0, 16'sd0, 16'sd0, 16'sd0, 1'b0, 1'b1);
        check("R3 final", q2);

        done = 1;
        finish_run();
    end

endmodule